// File: doc/BRIEF.md
# Debug-Port Memory Write Sequencer

This block runs on the host side of a 4-wire JTAG link. It stores one word or one byte into a RAM or peripheral location of a target microcontroller. A request carries a 20-bit address, 16 bits of data, a size flag and a two-bit variant code. The block turns the request into a fixed script and issues it on the link. The script mixes 8-bit instruction shifts, 16-bit and 20-bit data shifts, and manual edges on the separate target clock line `tclk`. The target latches the write on a rising edge of `tclk`.

The TAP port is generated from the system clock. Each half period of `tck` lasts `CLK_DIV` system cycles. The TAP controller is assumed to start in Run-Test/Idle, and every shift returns it there. Memory writes never read `tdo`, so the block has no `tdo` input. The instruction opcodes are parameters.

Variant codes are 0 (classic), 1 (extended), 2 (enhanced-emulation) and 3, which behaves as extended. The CPU must already be halted, or in emulation state for variant 2, before a request is made.

Top module: `jtag_mem_writer`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: `tck`, `tms` and `tdi` low, `tclk` high, `busy` and `done` low.
- R2: Variant 0 issues this script:
  - `tclk` falls.
  - Control instruction `OP_CTRL`, then 16-bit control word 0x2408 (word) or 0x2418 (byte). Bit 0 of the control word is 0, which selects write.
  - Address instruction `OP_ADDR`, then a 16-bit shift of address bits 15:0.
  - Data instruction `OP_DATA`, then the 16-bit data.
  - `tclk` rises.
- R3: Variants 1 and 3 issue the same script as R2, except that the address is shifted as a 20-bit data shift.
- R4: Variant 2 issues this script, with no other events:
  - `tclk` falls.
  - `OP_CTRL`, then control word 0x0500 (word) or 0x0510 (byte).
  - `OP_ADDR`, then the 20-bit address.
  - `tclk` rises.
  - `OP_DATA`, then the 16-bit data.
  - `tclk` falls.
  - `OP_CTRL`, then control word 0x0501.
  - `tclk` rises, falls, then rises.
- R5: Instruction shifts are 8 bits and data shifts are 16 or 20 bits, with the most significant bit first.
  - An instruction shift uses TMS 1,1,0,0, then the bits with TMS high only on the last bit, then TMS 1,0.
  - A data shift uses the same pattern but starts with TMS 1,0,0.
  - Every shift passes through Update-IR or Update-DR and ends in Run-Test/Idle.
- R6: `tck` is high for exactly `CLK_DIV` system cycles each time. `tms` and `tdi` never change while `tck` is high or on the cycle `tck` rises. `tck` is low whenever the block is idle.
- R7: A variant 0, 1 or 3 request skips the control instruction and control word when all of these hold:
  - it has the same variant code and size flag as the previous completed write;
  - that previous write was not variant 2.
  
  Such a request issues the `tclk` fall, then goes straight to the address instruction. After a variant 2 write, or after a change of variant or size, the full script runs.
- R8: `req` is sampled only while `busy` is low. A request raised while busy changes nothing in the script being issued and starts no further write.
- R9: `done` is high for exactly one cycle. That cycle is the one in which the final `tclk` rise appears. In that same cycle `busy` is already low.
- R10: `tclk` changes only while `tck` is low and the TAP is in Run-Test/Idle, never during a shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Write request, sampled while idle |
| variant | input | 2 | Script select: 0 classic, 1 extended, 2 enhanced-emulation, 3 as extended |
| byte_mode | input | 1 | 1 selects a byte write, 0 a word write |
| addr | input | 20 | Target address (variant 0 uses bits 15:0) |
| data | input | 16 | Value to store |
| busy | output | 1 | A script is in progress |
| done | output | 1 | One-cycle pulse with the final `tclk` rise |
| tck | output | 1 | TAP clock |
| tms | output | 1 | TAP mode select |
| tdi | output | 1 | TAP serial data to the target |
| tclk | output | 1 | Target clock line driven by hand |

## Verification
The in-line properties check the following on every cycle:
- `tms` and `tdi` hold steady across each `tck` rise;
- `tck` rests low while idle;
- `tclk` is frozen throughout a shift;
- the `done` pulse is one cycle long, arrives with `tclk` high and `busy` low;
- an idle block stays idle without a request.

The script content can only be shown by the bench's scenarios. A model of the target's TAP rebuilds each instruction and data value and logs every `tclk` edge, and the log is compared against the expected script. The scenarios cover the control words for each size, the 16-bit versus 20-bit address shift, the enhanced-emulation tail, the shortened follow-on write and requests that arrive while busy.

// File: rtl/jtag_mem_writer.sv
`timescale 1ns/1ps
module jtag_mem_writer #(
  parameter int CLK_DIV = 2,
  parameter logic [7:0] OP_CTRL = 8'h13,
  parameter logic [7:0] OP_ADDR = 8'h83,
  parameter logic [7:0] OP_DATA = 8'h85
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  variant,
  input  logic        byte_mode,
  input  logic [19:0] addr,
  input  logic [15:0] data,
  output logic        busy,
  output logic        done,
  output logic        tck,
  output logic        tms,
  output logic        tdi,
  output logic        tclk
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_SHIFT} state_t;
  typedef enum logic [1:0] {K_LO, K_HI, K_IR, K_DR} kind_t;

  state_t      st;
  kind_t       kind;
  logic [3:0]  step;
  logic [4:0]  len;
  logic [19:0] val;
  logic        fin;
  logic [CW-1:0] cnt;
  logic [4:0]  k;
  logic [1:0]  v_q, pv;
  logic        b_q, pb, skip, ctrl_ok;
  logic [19:0] a_q;
  logic [15:0] d_q;
  logic [3:0]  nstep;
  logic [4:0]  klast;

  function automatic logic [1:0] bit_at(input int i, input logic ir, input int n, input logic [19:0] v);
    int pre;
    logic [19:0] s;
    pre = ir ? 4 : 3;
    if (i < pre) return {(ir ? (i < 2) : (i == 0)), 1'b0};
    if (i < pre + n) begin
      s = v >> (pre + n - 1 - i);
      return {(i == pre + n - 1), s[0]};
    end
    return {(i == pre + n), 1'b0};
  endfunction

  always_comb begin
    kind = K_LO; len = 5'd0; val = 20'd0; fin = 1'b0;
    if (v_q == 2'd2) begin
      case (step)
        4'd1, 4'd9: begin kind = K_IR; len = 5'd8; val = {12'd0, OP_CTRL}; end
        4'd2:  begin kind = K_DR; len = 5'd16; val = {4'd0, b_q ? 16'h0510 : 16'h0500}; end
        4'd3:  begin kind = K_IR; len = 5'd8; val = {12'd0, OP_ADDR}; end
        4'd4:  begin kind = K_DR; len = 5'd20; val = a_q; end
        4'd5, 4'd11, 4'd13: begin kind = K_HI; fin = (step == 4'd13); end
        4'd6:  begin kind = K_IR; len = 5'd8; val = {12'd0, OP_DATA}; end
        4'd7:  begin kind = K_DR; len = 5'd16; val = {4'd0, d_q}; end
        4'd10: begin kind = K_DR; len = 5'd16; val = 20'h00501; end
        default: kind = K_LO;
      endcase
    end else begin
      case (step)
        4'd1: begin kind = K_IR; len = 5'd8; val = {12'd0, OP_CTRL}; end
        4'd2: begin kind = K_DR; len = 5'd16; val = {4'd0, b_q ? 16'h2418 : 16'h2408}; end
        4'd3: begin kind = K_IR; len = 5'd8; val = {12'd0, OP_ADDR}; end
        4'd4: begin
          kind = K_DR;
          len  = (v_q == 2'd0) ? 5'd16 : 5'd20;
          val  = (v_q == 2'd0) ? {4'd0, a_q[15:0]} : a_q;
        end
        4'd5: begin kind = K_IR; len = 5'd8; val = {12'd0, OP_DATA}; end
        4'd6: begin kind = K_DR; len = 5'd16; val = {4'd0, d_q}; end
        4'd7: begin kind = K_HI; fin = 1'b1; end
        default: kind = K_LO;
      endcase
    end
  end

  assign nstep = (step == 4'd0 && skip) ? 4'd3 : step + 4'd1;
  assign klast = ((kind == K_IR) ? 5'd4 : 5'd3) + len + 5'd1;
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= 4'd0; cnt <= '0; k <= 5'd0;
      tck <= 1'b0; tms <= 1'b0; tdi <= 1'b0; tclk <= 1'b1; done <= 1'b0;
      v_q <= 2'd0; b_q <= 1'b0; a_q <= 20'd0; d_q <= 16'd0;
      pv <= 2'd0; pb <= 1'b0; skip <= 1'b0; ctrl_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          v_q <= variant; b_q <= byte_mode; a_q <= addr; d_q <= data;
          skip <= ctrl_ok && (variant != 2'd2) && (variant == pv) && (byte_mode == pb);
          step <= 4'd0;
          st <= S_STEP;
        end
        S_STEP: begin
          if (kind == K_LO || kind == K_HI) begin
            tclk <= (kind == K_HI);
            if (fin) begin
              done <= 1'b1;
              st <= S_IDLE;
              ctrl_ok <= (v_q != 2'd2);
              pv <= v_q;
              pb <= b_q;
            end else begin
              step <= nstep;
            end
          end else begin
            {tms, tdi} <= bit_at(0, kind == K_IR, int'(len), val);
            k <= 5'd0;
            cnt <= '0;
            st <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (cnt == CW'(CLK_DIV - 1)) begin
            cnt <= '0;
            if (!tck) begin
              tck <= 1'b1;
            end else begin
              tck <= 1'b0;
              if (k == klast) begin
                tms <= 1'b0; tdi <= 1'b0;
                step <= nstep;
                st <= S_STEP;
              end else begin
                k <= k + 5'd1;
                {tms, tdi} <= bit_at(int'(k) + 1, kind == K_IR, int'(len), val);
              end
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pins_steady_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> ($stable(tms) && $stable(tdi)));
  p_tck_rests_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
  p_tclk_frozen_in_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |-> $stable(tclk));
  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_with_tclk_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tclk && !busy));
  p_idle_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> !busy);
endmodule

// File: tb/jtag_mem_writer_test.sv
`timescale 1ns/1ps
module jtag_mem_writer_test;
  localparam int DIV = 2;
  localparam logic [7:0] OPC = 8'h13, OPA = 8'h83, OPD = 8'h85;
  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7,
                 UDR = 8, SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, byte_mode = 1'b0;
  logic [1:0] variant = 2'd0;
  logic [19:0] addr = 20'd0;
  logic [15:0] data = 16'd0;
  logic busy, done, tck, tms, tdi, tclk;

  jtag_mem_writer #(.CLK_DIV(DIV), .OP_CTRL(OPC), .OP_ADDR(OPA), .OP_DATA(OPD)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .variant(variant), .byte_mode(byte_mode),
    .addr(addr), .data(data), .busy(busy), .done(done), .tck(tck), .tms(tms),
    .tdi(tdi), .tclk(tclk));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int tap, sn, hi_cnt, bad6, bad10, n_act;
  logic [31:0] sr;
  logic tck_p, tclk_p, tms_p, tdi_p;
  logic [31:0] act [0:1023];
  logic [31:0] ex [0:31];
  int n_ex;
  bit ok_b = 0, pb_b = 0;
  logic [1:0] pv_b = 2'd0;

  function automatic int tap_nx(input int s, input logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      CDR, SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR : PDR;
      PDR: return m ? E2DR : PDR;
      E2DR: return m ? UDR : SHDR;
      UDR, UIR: return m ? SDR : RTI;
      SIR: return m ? TLR : CIR;
      CIR, SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR : PIR;
      PIR: return m ? E2IR : PIR;
      default: return m ? UIR : SHIR;
    endcase
  endfunction

  function automatic logic [31:0] ent(input int t, input int l, input logic [19:0] v);
    return {3'(t), 5'(l), 4'd0, v};
  endfunction

  always @(negedge clk) begin
    int nx;
    if (!rst_n) begin
      tap = RTI; sn = 0; sr = 0; hi_cnt = 0; bad6 = 0; bad10 = 0; n_act = 0;
      tck_p = 1'b0; tclk_p = 1'b1; tms_p = 1'b0; tdi_p = 1'b0;
    end else begin
      if (tck && !tck_p) begin
        if (tap == SHDR || tap == SHIR) begin sr = {sr[30:0], tdi}; sn++; end
        if (tap == CDR || tap == CIR) begin sr = 0; sn = 0; end
        nx = tap_nx(tap, tms);
        if (nx == UDR) begin act[n_act % 1024] = ent(2, sn, sr[19:0]); n_act++; end
        if (nx == UIR) begin act[n_act % 1024] = ent(1, sn, sr[19:0]); n_act++; end
        tap = nx;
      end
      if (tck) hi_cnt++;
      if (!tck && tck_p) begin
        if (hi_cnt != DIV) bad6++;
        hi_cnt = 0;
      end
      if (tck && tck_p && (tms != tms_p || tdi != tdi_p)) bad6++;
      if (!busy && tck) bad6++;
      if (tclk != tclk_p) begin
        if (tap != RTI || tck) bad10++;
        act[n_act % 1024] = ent(tclk ? 4 : 3, 0, 20'd0);
        n_act++;
      end
      tck_p = tck; tclk_p = tclk; tms_p = tms; tdi_p = tdi;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic put(input logic [31:0] e);
    ex[n_ex] = e;
    n_ex++;
  endtask

  task automatic build(input logic [1:0] v, input bit b, input logic [19:0] a,
                       input logic [15:0] d, input bit skip);
    n_ex = 0;
    put(ent(3, 0, 0));
    if (v == 2'd2) begin
      put(ent(1, 8, {12'd0, OPC})); put(ent(2, 16, b ? 20'h00510 : 20'h00500));
      put(ent(1, 8, {12'd0, OPA})); put(ent(2, 20, a));
      put(ent(4, 0, 0));
      put(ent(1, 8, {12'd0, OPD})); put(ent(2, 16, {4'd0, d}));
      put(ent(3, 0, 0));
      put(ent(1, 8, {12'd0, OPC})); put(ent(2, 16, 20'h00501));
      put(ent(4, 0, 0)); put(ent(3, 0, 0)); put(ent(4, 0, 0));
    end else begin
      if (!skip) begin
        put(ent(1, 8, {12'd0, OPC})); put(ent(2, 16, b ? 20'h02418 : 20'h02408));
      end
      put(ent(1, 8, {12'd0, OPA}));
      if (v == 2'd0) put(ent(2, 16, {4'd0, a[15:0]}));
      else put(ent(2, 20, a));
      put(ent(1, 8, {12'd0, OPD})); put(ent(2, 16, {4'd0, d}));
      put(ent(4, 0, 0));
    end
  endtask

  task automatic run_write(input logic [1:0] v, input bit b, input logic [19:0] a,
                           input logic [15:0] d, input string tag, input bit poke);
    int base, bad_i;
    bit skip, idle_ok;
    skip = ok_b && v != 2'd2 && v == pv_b && b == pb_b;
    build(v, b, a, d, skip);
    @(negedge clk);
    base = n_act;
    variant = v; byte_mode = b; addr = a; data = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      variant = v + 2'd1; byte_mode = !b; addr = ~a; data = ~d; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(tclk && !busy, "R9 done with tclk high and busy low", {30'd0, tclk, busy}, 32'h2);
    @(negedge clk);
    chk(!done, "R9 done lasts one cycle", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(tap == RTI, "R5 TAP back in Run-Test/Idle", tap, RTI);
    chk(n_act - base == n_ex, {tag, " event count"}, n_act - base, n_ex);
    bad_i = -1;
    for (int i = 0; i < n_ex && i < n_act - base; i++)
      if (bad_i < 0 && act[(base + i) % 1024] !== ex[i]) bad_i = i;
    if (bad_i >= 0) chk(0, {tag, " script event"}, act[(base + bad_i) % 1024], ex[bad_i]);
    else chk(1, tag, 0, 0);
    if (poke) begin
      idle_ok = 1;
      repeat (5) begin @(negedge clk); if (busy) idle_ok = 0; end
      chk(idle_ok && n_act - base == n_ex, "R8 request while busy ignored", {31'd0, idle_ok}, 32'd1);
    end
    ok_b = (v != 2'd2); pv_b = v; pb_b = b;
  endtask

  initial begin
    #1600000;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [1:0] v;
    bit b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({tck, tms, tdi, tclk, busy, done} == 6'b000100, "R1 outputs during reset",
        {26'd0, tck, tms, tdi, tclk, busy, done}, 32'h04);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({tck, tms, tdi, tclk, busy, done} == 6'b000100, "R1 outputs after reset",
        {26'd0, tck, tms, tdi, tclk, busy, done}, 32'h04);

    run_write(2'd0, 0, 20'hABCDE, 16'h1234, "R2 classic word", 0);
    run_write(2'd0, 1, 20'h00200, 16'h00FF, "R2 classic byte after size change", 0);
    run_write(2'd0, 1, 20'h00202, 16'h0055, "R7 classic byte repeat shortened", 0);
    run_write(2'd1, 0, 20'hF0F0F, 16'hFFFF, "R3 extended word 20-bit address", 0);
    run_write(2'd1, 0, 20'h80001, 16'h8001, "R7 extended word repeat shortened", 0);
    run_write(2'd3, 0, 20'h12345, 16'h0000, "R3 code 3 as extended, full script", 0);
    run_write(2'd2, 0, 20'h7FFFF, 16'hA5A5, "R4 enhanced word", 0);
    run_write(2'd2, 1, 20'h00001, 16'h5A5A, "R4 enhanced byte", 0);
    run_write(2'd2, 1, 20'h00003, 16'h0101, "R4 R7 enhanced repeat stays full", 0);
    run_write(2'd1, 1, 20'h3C3C3, 16'hC3C3, "R7 full script after enhanced", 0);
    run_write(2'd0, 0, 20'h55555, 16'hBEEF, "R8 classic with request while busy", 1);

    v = 2'd0; b = 0;
    for (int n = 0; n < 30; n++) begin
      if ($urandom % 10 > 2) begin
        v = 2'($urandom % 4);
        b = 1'($urandom % 2);
      end
      run_write(v, b, 20'($urandom), 16'($urandom), "R2 R3 R4 R7 random write", 0);
    end

    chk(bad6 == 0, "R6 tck high width and pin stability", bad6, 0);
    chk(bad10 == 0, "R10 tclk moves only in idle TAP with tck low", bad10, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule